// File: doc/BRIEF.md
# Split-Port Bus Bridge

This block sits between a processor core built around separate instruction and data ports, each with a zero-latency read, and a single shared memory-mapped master port that uses a wait-request handshake. Every step of the core becomes a short sequence on the shared bus. First the bridge fetches the instruction. Then it performs the step's data read or data write, if the core asks for one. When everything for that step has completed and any read data has been captured, the bridge pulses a clock-enable to the core for one cycle so the core can advance.

While any request is stalled by the memory, the bridge keeps it unchanged. Read data is taken only from the cycle that follows the acceptance of the read. The bridge also owns the run/halt handshake. The run flag is high through reset and while the core runs. It drops for good when the core asks to fetch from address zero; after that the bridge stays silent on the bus until the next reset. The core's own program counter supplies the post-reset start address, 0xBFC00000. The bridge does not align byte lanes: partial stores come in with a lane mask from the core.

Top module: `split_bus_bridge`

## Requirements
- R1: While `reset` is high, `active` is 1, `busRead` and `busWrite` are 0, and `coreEnable` is 0.
- R2: The first bus transaction accepted after reset is a read at the core's `instrAddr` (0xBFC00000 from a freshly reset core) with `busByteEn` = 4'b1111.
- R3: While `busWait` is high during a request, `busAddr`, `busRead`, `busWrite`, `busWdata` and `busByteEn` keep the same values into the next cycle.
- R4: Each step starts with exactly one fetch read at `instrAddr`. `instrData` presented with `coreEnable` equals the `busRdata` value driven in the cycle right after that read was accepted, and not the value driven in the acceptance cycle.
- R5: When the core raises `dataRead`, the fetch is followed by one read at `dataAddr` with `busByteEn` = 4'b1111. `dataRdata` presented with `coreEnable` is the `busRdata` from the cycle after that read's acceptance.
- R6: When the core raises `dataWrite`, the fetch is followed by one write carrying `dataAddr`, `dataWdata` and `dataByteEn` unchanged (4'b1111 for a full word, a partial mask for a partial store).
- R7: When the core requests no data access, the step has only the fetch on the bus.
- R8: `coreEnable` is high for exactly one cycle per step, only after every transaction of that step has been accepted, and never in a cycle with a bus request.
- R9: If `instrAddr` is 0 when a fetch is due, no read is issued. `active` goes low in the next cycle, and from then on until reset there are no reads, no writes and no `coreEnable`.
- R10: `busRead` and `busWrite` are never high in the same cycle.
- R11: A reset after a halt brings `active` back high, and fetching starts again from the core's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every signal is synchronous to it |
| reset | input | 1 | Synchronous, level-sensitive reset, active high |
| active | output | 1 | High through reset and while running; low once halted |
| coreEnable | output | 1 | One-cycle step enable to the core |
| instrAddr | input | 32 | Core instruction address |
| instrData | output | 32 | Captured instruction word |
| dataAddr | input | 32 | Core data address |
| dataRead | input | 1 | Core requests a data read this step |
| dataWrite | input | 1 | Core requests a data write this step |
| dataWdata | input | 32 | Core store data |
| dataByteEn | input | 4 | Core byte-lane mask for stores |
| dataRdata | output | 32 | Captured load data |
| busAddr | output | 32 | Shared bus address |
| busRead | output | 1 | Shared bus read strobe |
| busWrite | output | 1 | Shared bus write strobe |
| busWait | input | 1 | Memory stall: the current request is not accepted this cycle |
| busWdata | output | 32 | Shared bus write data |
| busByteEn | output | 4 | Shared bus byte enables |
| busRdata | input | 32 | Shared bus read data, valid the cycle after acceptance |

## Verification
A wrong sequencer state shows at the ports within one or two cycles. A skipped capture cycle latches the garbage word that the memory drives during the acceptance cycle, which surfaces as a wrong `instrData` or `dataRdata` at the very next enable pulse. A state that leaves a stall early changes the address or strobes under a high `busWait` in the following cycle. A missed or extra phase changes the number of accepted transactions counted between two enable pulses. A broken halt path shows within two cycles of the final step, either as a read at address zero or as `active` staying high. Every check is repeated over stall lengths of zero to three cycles per transaction, across no-access, load, full-word store and partial store steps.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FLAT,
    ST_DATA,
    ST_DLAT,
    ST_STEP,
    ST_HALT
  } bridgeState_e;

  // Strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic fetchReq;
    logic dataReq;
    logic capInstr;
    logic capData;
  } bridgeCtl_t;

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       reset,
  input  logic       busWait,
  input  logic       fetchZero,
  input  logic       dataRead,
  input  logic       dataWrite,
  output bridgeCtl_t ctl,
  output logic       active,
  output logic       coreEnable
);

  bridgeState_e state, nextState;

  always_ff @(posedge clk) begin
    if (reset) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  nextState = ST_FETCH;
      ST_FETCH: begin
        if (fetchZero)     nextState = ST_HALT;
        else if (!busWait) nextState = ST_FLAT;
      end
      ST_FLAT:  nextState = ST_DATA;
      ST_DATA: begin
        if (dataRead) begin
          if (!busWait) nextState = ST_DLAT;
        end else if (dataWrite) begin
          if (!busWait) nextState = ST_STEP;
        end else begin
          nextState = ST_STEP;
        end
      end
      ST_DLAT:  nextState = ST_STEP;
      ST_STEP:  nextState = ST_FETCH;
      ST_HALT:  nextState = ST_HALT;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.fetchReq = !reset && (state == ST_FETCH) && !fetchZero;
    ctl.dataReq  = !reset && (state == ST_DATA) && (dataRead || dataWrite);
    ctl.capInstr = !reset && (state == ST_FLAT);
    ctl.capData  = !reset && (state == ST_DLAT);
  end

  assign active     = reset || (state != ST_HALT);
  assign coreEnable = !reset && (state == ST_STEP);

endmodule

// File: rtl/bridge_dpath.sv
module bridge_dpath
  import bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned HALT_ADDR = 0
) (
  input  logic                clk,
  input  logic                reset,
  input  bridgeCtl_t          ctl,
  input  logic [ADDR_W-1:0]   instrAddr,
  input  logic [ADDR_W-1:0]   dataAddr,
  input  logic                dataRead,
  input  logic                dataWrite,
  input  logic [DATA_W-1:0]   dataWdata,
  input  logic [DATA_W/8-1:0] dataByteEn,
  input  logic [DATA_W-1:0]   busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busRead,
  output logic                busWrite,
  output logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W/8-1:0] busByteEn,
  output logic [DATA_W-1:0]   instrData,
  output logic [DATA_W-1:0]   dataRdata,
  output logic                fetchZero
);

  localparam int unsigned BE_W = DATA_W / 8;

  logic rdData, wrData;

  // A read wins if the core ever raises both strobes.
  assign rdData    = ctl.dataReq && dataRead;
  assign wrData    = ctl.dataReq && dataWrite && !dataRead;
  assign fetchZero = (instrAddr == ADDR_W'(HALT_ADDR));

  always_comb begin
    busAddr = '0;
    if (ctl.fetchReq)     busAddr = instrAddr;
    else if (ctl.dataReq) busAddr = dataAddr;
  end

  assign busRead  = ctl.fetchReq || rdData;
  assign busWrite = wrData;
  assign busWdata = wrData ? dataWdata : '0;

  always_comb begin
    if (wrData)       busByteEn = dataByteEn;
    else if (busRead) busByteEn = {BE_W{1'b1}};
    else              busByteEn = '0;
  end

  always_ff @(posedge clk) begin
    if (reset) begin
      instrData <= '0;
      dataRdata <= '0;
    end else begin
      if (ctl.capInstr) instrData <= busRdata;
      if (ctl.capData)  dataRdata <= busRdata;
    end
  end

endmodule

// File: rtl/split_bus_bridge.sv
module split_bus_bridge
  import bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned HALT_ADDR = 0
) (
  input  logic                clk,
  input  logic                reset,
  output logic                active,
  output logic                coreEnable,
  input  logic [ADDR_W-1:0]   instrAddr,
  output logic [DATA_W-1:0]   instrData,
  input  logic [ADDR_W-1:0]   dataAddr,
  input  logic                dataRead,
  input  logic                dataWrite,
  input  logic [DATA_W-1:0]   dataWdata,
  input  logic [DATA_W/8-1:0] dataByteEn,
  output logic [DATA_W-1:0]   dataRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busRead,
  output logic                busWrite,
  input  logic                busWait,
  output logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W/8-1:0] busByteEn,
  input  logic [DATA_W-1:0]   busRdata
);

  bridgeCtl_t ctl;
  logic       fetchZero;

  bridge_ctrl u_ctrl (
    .clk        (clk),
    .reset      (reset),
    .busWait    (busWait),
    .fetchZero  (fetchZero),
    .dataRead   (dataRead),
    .dataWrite  (dataWrite),
    .ctl        (ctl),
    .active     (active),
    .coreEnable (coreEnable)
  );

  bridge_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .HALT_ADDR (HALT_ADDR)
  ) u_dpath (
    .clk        (clk),
    .reset      (reset),
    .ctl        (ctl),
    .instrAddr  (instrAddr),
    .dataAddr   (dataAddr),
    .dataRead   (dataRead),
    .dataWrite  (dataWrite),
    .dataWdata  (dataWdata),
    .dataByteEn (dataByteEn),
    .busRdata   (busRdata),
    .busAddr    (busAddr),
    .busRead    (busRead),
    .busWrite   (busWrite),
    .busWdata   (busWdata),
    .busByteEn  (busByteEn),
    .instrData  (instrData),
    .dataRdata  (dataRdata),
    .fetchZero  (fetchZero)
  );

endmodule

// File: rtl/bridge_checks.sv
module bridge_checks #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                reset,
  input logic                active,
  input logic                coreEnable,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busRead,
  input logic                busWrite,
  input logic                busWait,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W/8-1:0] busByteEn
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    reset |-> (active && !busRead && !busWrite && !coreEnable));

  p_hold_on_wait_r3: assert property (@(posedge clk) disable iff (reset)
    ((busRead || busWrite) && busWait) |=>
      ($stable(busAddr) && $stable(busRead) && $stable(busWrite) &&
       $stable(busWdata) && $stable(busByteEn)));

  p_enable_pulse_r8: assert property (@(posedge clk) disable iff (reset)
    coreEnable |=> !coreEnable);

  p_enable_bus_idle_r8: assert property (@(posedge clk) disable iff (reset)
    coreEnable |-> (!busRead && !busWrite));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (reset)
    !active |=> (!active && !busRead && !busWrite && !coreEnable));

  p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (reset)
    !(busRead && busWrite));

endmodule

bind split_bus_bridge bridge_checks #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_checks (
  .clk        (clk),
  .reset      (reset),
  .active     (active),
  .coreEnable (coreEnable),
  .busAddr    (busAddr),
  .busRead    (busRead),
  .busWrite   (busWrite),
  .busWait    (busWait),
  .busWdata   (busWdata),
  .busByteEn  (busByteEn)
);

// File: tb/tb_split_bus_bridge.sv
`timescale 1ns/1ps
module tb_split_bus_bridge;

  localparam int NSTEP = 16;

  logic        clk = 1'b0;
  logic        reset = 1'b1;
  logic        active, coreEnable;
  logic [31:0] instrAddr, instrData, dataAddr, dataWdata, dataRdata;
  logic        dataRead, dataWrite;
  logic [3:0]  dataByteEn;
  logic [31:0] busAddr, busWdata;
  logic        busRead, busWrite;
  logic        busWait = 1'b0;
  logic [3:0]  busByteEn;
  logic [31:0] busRdata = 32'h0;

  always #2 clk = ~clk;

  split_bus_bridge dut (
    .clk(clk), .reset(reset), .active(active), .coreEnable(coreEnable),
    .instrAddr(instrAddr), .instrData(instrData), .dataAddr(dataAddr),
    .dataRead(dataRead), .dataWrite(dataWrite), .dataWdata(dataWdata),
    .dataByteEn(dataByteEn), .dataRdata(dataRdata), .busAddr(busAddr),
    .busRead(busRead), .busWrite(busWrite), .busWait(busWait),
    .busWdata(busWdata), .busByteEn(busByteEn), .busRdata(busRdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Arithmetic memory contents and core program
  function automatic logic [31:0] instrWord(input int idx);
    return 32'hA500_0000 ^ (32'(idx) * 32'h0001_0203);
  endfunction
  function automatic logic [31:0] dataInit(input int k);
    return 32'h0D00_0000 + 32'(k) * 32'h0000_1111;
  endfunction
  function automatic int dataSlot(input int s);
    return ((s + 1) / 2) % 4;
  endfunction
  function automatic logic [3:0] stepBe(input int s);
    if (s % 4 == 2) return 4'hF;
    return ((s / 4) % 2 == 1) ? 4'b1100 : 4'b0010;
  endfunction
  function automatic logic [31:0] stepWdata(input int s, input int cfg);
    return 32'h7700_0000 + 32'(s) * 32'h0001_0101 + 32'(cfg) * 32'h0100_0000;
  endfunction

  int cfgWait = 0;
  int stepIdx = 0;

  // Core model: kind 0 none, 1 load, 2 full store, 3 partial store
  always_comb begin
    instrAddr  = (stepIdx < NSTEP) ? 32'hBFC0_0000 + 32'(4 * stepIdx) : 32'h0;
    dataRead   = (stepIdx < NSTEP) && (stepIdx % 4 == 1);
    dataWrite  = (stepIdx < NSTEP) && (stepIdx % 4 >= 2);
    dataAddr   = 32'h1000_0080 + 32'(4 * dataSlot(stepIdx));
    dataWdata  = stepWdata(stepIdx, cfgWait);
    dataByteEn = stepBe(stepIdx);
  end

  logic [31:0] mem [64];
  logic [31:0] shadow [4];
  int          waitCnt = 0;
  bit          prevWaited = 0;
  logic [31:0] pAddr, pWdata;
  logic        pRd, pWr;
  logic [3:0]  pBe;
  bit          rdNext = 0;
  int          rdIdx = 0;
  bit          firstSeen = 0;
  bit          prevEnable = 0;
  int          txCount = 0;
  logic [31:0] t0Addr, t1Addr, t1Wdata;
  logic        t0Rd, t1Rd, t1Wr;
  logic [3:0]  t0Be, t1Be;

  initial forever begin
    @(negedge clk);
    if (reset) begin
      chk(active && !busRead && !busWrite && !coreEnable, "R1", {28'h0, active, busRead, busWrite, coreEnable}, 32'h8);
      stepIdx = 0; waitCnt = 0; prevWaited = 0; rdNext = 0; firstSeen = 0;
      prevEnable = 0; txCount = 0; busWait = 1'b0;
      for (int i = 0; i < 64; i++) mem[i] = (i < 32) ? instrWord(i) : dataInit(i - 32);
      for (int k = 0; k < 4; k++) shadow[k] = dataInit(k);
    end else begin
      if (busRead && busAddr == 32'h0) chk(0, "R9", busAddr, 32'hFFFF_FFFF);
      if (!active && (busRead || busWrite || coreEnable))
        chk(0, "R9", {29'h0, busRead, busWrite, coreEnable}, 32'h0);
      if (busRead && busWrite) chk(0, "R10", 32'h3, 32'h0);
      if (prevWaited)
        chk(busAddr == pAddr && busRead == pRd && busWrite == pWr && busWdata == pWdata && busByteEn == pBe,
            "R3", busAddr, pAddr);
      if (coreEnable && prevEnable) chk(0, "R8", 32'h1, 32'h0);
      prevEnable = coreEnable;

      if (coreEnable) begin
        automatic int s = stepIdx;
        automatic int kind = s % 4;
        automatic int k = dataSlot(s);
        chk(!busRead && !busWrite, "R8", {30'h0, busRead, busWrite}, 32'h0);
        chk(txCount == ((kind == 0) ? 1 : 2), (kind == 0) ? "R7" : "R8", 32'(txCount), (kind == 0) ? 32'd1 : 32'd2);
        chk(t0Rd && t0Addr == instrAddr && t0Be == 4'hF, "R4", t0Addr, instrAddr);
        chk(instrData == instrWord(s), "R4", instrData, instrWord(s));
        if (kind == 1) begin
          chk(t1Rd && !t1Wr && t1Addr == dataAddr && t1Be == 4'hF, "R5", t1Addr, dataAddr);
          chk(dataRdata == shadow[k], "R5", dataRdata, shadow[k]);
        end else if (kind >= 2) begin
          chk(t1Wr && !t1Rd && t1Addr == dataAddr && t1Wdata == dataWdata && t1Be == stepBe(s),
              "R6", t1Wdata, dataWdata);
          for (int b = 0; b < 4; b++)
            if (stepBe(s)[b]) shadow[k][8*b +: 8] = dataWdata[8*b +: 8];
        end
        stepIdx = stepIdx + 1;
        txCount = 0;
      end

      // Memory model
      if (rdNext) begin
        busRdata = mem[rdIdx];
        rdNext = 0;
      end
      if (busRead || busWrite) begin
        if (waitCnt < cfgWait) begin
          busWait = 1'b1; waitCnt++; prevWaited = 1;
          pAddr = busAddr; pRd = busRead; pWr = busWrite; pWdata = busWdata; pBe = busByteEn;
        end else begin
          busWait = 1'b0; waitCnt = 0; prevWaited = 0;
          if (!firstSeen) begin
            chk(busRead && !busWrite && busAddr == 32'hBFC0_0000 && busByteEn == 4'hF, "R2", busAddr, 32'hBFC0_0000);
            firstSeen = 1;
          end
          if (txCount == 0) begin
            t0Addr = busAddr; t0Rd = busRead; t0Be = busByteEn;
          end else if (txCount == 1) begin
            t1Addr = busAddr; t1Rd = busRead; t1Wr = busWrite; t1Wdata = busWdata; t1Be = busByteEn;
          end
          txCount++;
          if (busWrite) begin
            for (int b = 0; b < 4; b++)
              if (busByteEn[b]) mem[busAddr[7:2]][8*b +: 8] = busWdata[8*b +: 8];
          end else begin
            rdNext = 1; rdIdx = int'(busAddr[7:2]);
            busRdata = 32'hDEAD_BEEF;
          end
        end
      end else begin
        busWait = 1'b0; prevWaited = 0;
      end
    end
  end

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      @(posedge clk); #1;
      cfgWait = cfg;
      reset = 1'b1;
      repeat (3) @(posedge clk);
      #1 reset = 1'b0;
      #1 chk(active == 1'b1, "R11", {31'h0, active}, 32'h1);
      while (stepIdx < NSTEP) @(posedge clk);
      repeat (3) @(posedge clk);
      #1 chk(active == 1'b0, "R9", {31'h0, active}, 32'h0);
      repeat (20) @(posedge clk);
      #1 chk(active == 1'b0, "R9", {31'h0, active}, 32'h0);
      for (int k = 0; k < 4; k++)
        chk(mem[32 + k] == shadow[k], "R6", mem[32 + k], shadow[k]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=%h expected=%h", stepIdx, NSTEP);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule